// File: doc/BRIEF.md
# External Bus Strobe Generator

This block produces the two timing strobes of a multiplexed external memory bus on a small 8-bit controller. The strobes are an address-latch pulse, active high, and a code-fetch read strobe, active low. A phase counter splits each machine cycle into twelve oscillator clocks. Inside that frame the address-latch pulse fires twice and the code-fetch strobe fires twice. The counter's phase is also brought out so that neighbouring logic can align to the machine cycle.

The instruction sequencer reports the nature of each machine cycle on four level inputs: an external data transfer, a code-table read, a software bit that quiets the address-latch pulse, and a strap that selects execution from external code memory. The block samples all four on the clock edge that starts a machine cycle and keeps them for the whole of that cycle. In a data-transfer cycle the second address-latch pulse and both read strobes are left out. When the quiet bit is set and code runs internally, the address-latch pulse appears only in data-transfer or table-read cycles. In the other cycles a separate weak-high indicator is raised in place of the pulse. The external-execution strap overrides the quiet bit.

Top module: `bus_strobe_gen`

## Requirements
- R1: `mc_phase` counts 0,1,…,11 and wraps from 11 to 0, advancing by one on every clock while reset is low.
- R2: In an ordinary cycle, `ale` is high at phases 0, 1, 6 and 7 and low at every other phase.
- R3: In a cycle sampled with `xdata_cycle` = 1, `ale` is high at phases 0 and 1 only. The pulse at phases 6 and 7 is dropped.
- R4: With `ext_code` = 1, `psen_n` is low at phases 3–5 and 9–11. With `ext_code` = 0 it stays high for the whole cycle.
- R5: In a cycle sampled with `xdata_cycle` = 1, `psen_n` stays high for all twelve phases.
- R6: With `ale_quiet` = 1 and `ext_code` = 0, a cycle with neither `xdata_cycle` nor `table_read` keeps `ale` low. In that cycle `ale_weak` is high for all twelve phases. In every other cycle `ale_weak` is low.
- R7: With `ale_quiet` = 1, a cycle with `xdata_cycle` or `table_read` set still pulses `ale` as R2 and R3 describe.
- R8: With `ext_code` = 1, the value of `ale_quiet` has no effect on `ale` or `ale_weak`.
- R9: While `rst` is high, `ale` = 0, `psen_n` = 1, `ale_weak` = 0 and `mc_phase` = 11. The first clock edge with `rst` low starts a machine cycle at phase 0.
- R10: The control inputs are sampled only on the edge where `mc_phase` goes from 11 to 0. A change at any other time does not alter the strobes of the current cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous reset, active high |
| xdata_cycle | input | 1 | Current machine cycle transfers external data |
| table_read | input | 1 | Current machine cycle reads a code table |
| ale_quiet | input | 1 | Software bit that quiets the address-latch pulse |
| ext_code | input | 1 | Strap: code executes from external memory |
| ale | output | 1 | Address-latch pulse, active high |
| psen_n | output | 1 | Code-fetch read strobe, active low |
| ale_weak | output | 1 | High while the address-latch pulse is quieted |
| mc_phase | output | 4 | Oscillator-clock phase within the machine cycle |

## Verification
The control inputs take effect through one register stage: the values present at the edge where `mc_phase` leaves 11 govern the strobes of the next twelve clocks. Each strobe output is a decode of registered state with no further register, so it is valid in the same clock as the phase it belongs to. Each scenario therefore drives its inputs, waits until `mc_phase` reads 11 at a falling edge, and then compares every output on each of the next twelve falling edges against the phase-indexed expectation. The timing scenario flips every control input in the middle of the cycle while still expecting the pattern of the values sampled at its start.

// File: rtl/bus_strobe_pkg.sv
package bus_strobe_pkg;

    // Attributes of one machine cycle, captured at its first edge
    typedef struct packed {
        logic valid;      // a machine cycle is running (cleared in reset)
        logic xdata;      // external data transfer cycle
        logic tbl;        // code-table read cycle
        logic quiet;      // address-latch pulse quieted by software
        logic ext;        // executing from external code memory
    } cyc_attr_t;

    localparam cyc_attr_t ATTR_IDLE = '0;

    // True when phase p lies in [start, start+width)
    function automatic logic in_window(input int p, input int start, input int width);
        return (p >= start) && (p < start + width);
    endfunction

    // Address-latch pulses are allowed in this cycle at all
    function automatic logic ale_allowed(input cyc_attr_t a);
        return a.valid && (!a.quiet || a.ext || a.xdata || a.tbl);
    endfunction

    // Address-latch pulse replaced by the weak-high indicator
    function automatic logic ale_weakened(input cyc_attr_t a);
        return a.valid && a.quiet && !a.ext && !a.xdata && !a.tbl;
    endfunction

    // Code-fetch strobes allowed in this cycle
    function automatic logic psen_allowed(input cyc_attr_t a);
        return a.valid && a.ext && !a.xdata;
    endfunction

endpackage

// File: rtl/mc_phase_counter.sv
module mc_phase_counter #(
    parameter int CLKS = 12,
    localparam int PW = $clog2(CLKS)
) (
    input  logic          clk,
    input  logic          rst,
    output logic [PW-1:0] phase,
    output logic          cycle_start
);
    localparam logic [PW-1:0] LAST = PW'(CLKS - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= LAST;
        end else if (phase == LAST) begin
            phase <= '0;
        end else begin
            phase <= phase + PW'(1);
        end
    end

    // Next edge opens a new machine cycle
    assign cycle_start = (phase == LAST);
endmodule

// File: rtl/cycle_attr_latch.sv
module cycle_attr_latch
    import bus_strobe_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      cycle_start,
    input  logic      xdata_cycle,
    input  logic      table_read,
    input  logic      ale_quiet,
    input  logic      ext_code,
    output cyc_attr_t attr
);
    always_ff @(posedge clk) begin
        if (rst) begin
            attr <= ATTR_IDLE;
        end else if (cycle_start) begin
            attr.valid <= 1'b1;
            attr.xdata <= xdata_cycle;
            attr.tbl   <= table_read;
            attr.quiet <= ale_quiet;
            attr.ext   <= ext_code;
        end
    end
endmodule

// File: rtl/strobe_decode.sv
module strobe_decode
    import bus_strobe_pkg::*;
#(
    parameter int CLKS      = 12,
    parameter int SLOTS     = 2,
    parameter int ALE_WIDTH = 2,
    parameter int RD_WIDTH  = 3,
    localparam int PW       = $clog2(CLKS),
    localparam int SLOT_LEN = CLKS / SLOTS,
    localparam int RD_OFS   = SLOT_LEN / 2
) (
    input  logic [PW-1:0] phase,
    input  cyc_attr_t     attr,
    output logic          ale,
    output logic          psen_n,
    output logic          ale_weak
);
    logic [SLOTS-1:0] ale_slot;
    logic [SLOTS-1:0] rd_slot;

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        // The last slot's latch pulse is dropped in a data-transfer cycle
        localparam bit DROP_ON_XDATA = (s == SLOTS - 1) && (SLOTS > 1);
        always_comb begin
            ale_slot[s] = in_window(int'(phase), s * SLOT_LEN, ALE_WIDTH)
                          && ale_allowed(attr)
                          && !(DROP_ON_XDATA && attr.xdata);
            rd_slot[s]  = in_window(int'(phase), s * SLOT_LEN + RD_OFS, RD_WIDTH)
                          && psen_allowed(attr);
        end
    end

    assign ale      = |ale_slot;
    assign psen_n   = ~(|rd_slot);
    assign ale_weak = ale_weakened(attr);
endmodule

// File: rtl/bus_strobe_gen.sv
module bus_strobe_gen
    import bus_strobe_pkg::*;
#(
    parameter int CLKS      = 12,
    parameter int SLOTS     = 2,
    parameter int ALE_WIDTH = 2,
    parameter int RD_WIDTH  = 3,
    localparam int PW       = $clog2(CLKS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          xdata_cycle,
    input  logic          table_read,
    input  logic          ale_quiet,
    input  logic          ext_code,
    output logic          ale,
    output logic          psen_n,
    output logic          ale_weak,
    output logic [PW-1:0] mc_phase
);
    logic      cycle_start;
    cyc_attr_t attr;

    mc_phase_counter #(.CLKS(CLKS)) u_phase (
        .clk         (clk),
        .rst         (rst),
        .phase       (mc_phase),
        .cycle_start (cycle_start)
    );

    cycle_attr_latch u_attr (
        .clk         (clk),
        .rst         (rst),
        .cycle_start (cycle_start),
        .xdata_cycle (xdata_cycle),
        .table_read  (table_read),
        .ale_quiet   (ale_quiet),
        .ext_code    (ext_code),
        .attr        (attr)
    );

    strobe_decode #(
        .CLKS      (CLKS),
        .SLOTS     (SLOTS),
        .ALE_WIDTH (ALE_WIDTH),
        .RD_WIDTH  (RD_WIDTH)
    ) u_dec (
        .phase    (mc_phase),
        .attr     (attr),
        .ale      (ale),
        .psen_n   (psen_n),
        .ale_weak (ale_weak)
    );
endmodule

// File: rtl/bus_strobe_chk.sv
module bus_strobe_chk #(
    parameter int CLKS = 12,
    localparam int PW  = $clog2(CLKS)
) (
    input logic          clk,
    input logic          rst,
    input logic          xdata_cycle,
    input logic          ext_code,
    input logic          ale,
    input logic          psen_n,
    input logic          ale_weak,
    input logic [PW-1:0] mc_phase
);
    localparam logic [PW-1:0] LAST = PW'(CLKS - 1);
    localparam logic [PW-1:0] HALF = PW'(CLKS / 2);

    logic seen_xdata, seen_ext, rst_d;

    // Checker-side record of the cycle type seen at the cycle boundary
    always_ff @(posedge clk) begin
        rst_d <= rst;
        if (rst) begin
            seen_xdata <= 1'b0;
            seen_ext   <= 1'b0;
        end else if (mc_phase == LAST) begin
            seen_xdata <= xdata_cycle;
            seen_ext   <= ext_code;
        end
    end

    // R1
    phase_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (mc_phase == LAST) |=> (mc_phase == '0));

    // R1
    phase_step_chk: assert property (@(posedge clk) disable iff (rst)
        (mc_phase != LAST) |=> (mc_phase == $past(mc_phase) + PW'(1)));

    // R3
    xdata_late_ale_chk: assert property (@(posedge clk) disable iff (rst)
        (seen_xdata && mc_phase >= HALF) |-> !ale);

    // R4
    internal_no_rd_chk: assert property (@(posedge clk) disable iff (rst)
        !seen_ext |-> psen_n);

    // R5
    xdata_no_rd_chk: assert property (@(posedge clk) disable iff (rst)
        seen_xdata |-> psen_n);

    // R8
    ext_first_ale_chk: assert property (@(posedge clk) disable iff (rst)
        (seen_ext && mc_phase == '0) |-> (ale && !ale_weak));

    // R2
    strobe_apart_chk: assert property (@(posedge clk) disable iff (rst)
        ale |-> psen_n);

    // R9
    always @(negedge clk) begin
        if (rst && rst_d) begin
            reset_idle_chk: assert (!ale && psen_n && !ale_weak && mc_phase == LAST);
        end
    end
endmodule

bind bus_strobe_gen bus_strobe_chk #(.CLKS(CLKS)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .xdata_cycle (xdata_cycle),
    .ext_code    (ext_code),
    .ale         (ale),
    .psen_n      (psen_n),
    .ale_weak    (ale_weak),
    .mc_phase    (mc_phase)
);

// File: tb/bus_strobe_gen_test.sv
module bus_strobe_gen_test;
    timeunit 1ns;
    timeprecision 1ps;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       xdata_cycle = 1'b0;
    logic       table_read = 1'b0;
    logic       ale_quiet = 1'b0;
    logic       ext_code = 1'b0;
    logic       ale, psen_n, ale_weak;
    logic [3:0] mc_phase;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    bus_strobe_gen uut (
        .clk(clk), .rst(rst), .xdata_cycle(xdata_cycle), .table_read(table_read),
        .ale_quiet(ale_quiet), .ext_code(ext_code), .ale(ale), .psen_n(psen_n),
        .ale_weak(ale_weak), .mc_phase(mc_phase)
    );

    always #4 clk = ~clk;

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // One machine cycle with the given attributes, checked phase by phase
    task automatic run_cycle(input string req, input bit xd, input bit tb, input bit qt,
                             input bit ex, input bit flip_mid);
        xdata_cycle = xd; table_read = tb; ale_quiet = qt; ext_code = ex;
        do @(negedge clk); while (mc_phase != 4'd11);
        for (int p = 0; p < 12; p++) begin
            bit en, exp_ale, exp_rd, exp_weak;
            @(negedge clk);
            en       = !qt || ex || xd || tb;
            exp_ale  = en && ((p < 2) || ((p == 6 || p == 7) && !xd));
            exp_rd   = ex && !xd && ((p >= 3 && p <= 5) || (p >= 9));
            exp_weak = qt && !ex && !xd && !tb;
            check(req, $sformatf("phase at step %0d", p), int'(mc_phase), p);
            check(req, $sformatf("ale at phase %0d", p), int'(ale), int'(exp_ale));
            check(req, $sformatf("psen_n at phase %0d", p), int'(psen_n), int'(!exp_rd));
            check(req, $sformatf("ale_weak at phase %0d", p), int'(ale_weak), int'(exp_weak));
            if (flip_mid && p == 5) begin
                xdata_cycle = !xd; table_read = !tb; ale_quiet = !qt; ext_code = !ex;
            end
        end
    endtask

    task automatic test_reset();
        rst = 1'b1;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check("R9", "ale in reset", int'(ale), 0);
            check("R9", "psen_n in reset", int'(psen_n), 1);
            check("R9", "ale_weak in reset", int'(ale_weak), 0);
            check("R9", "phase in reset", int'(mc_phase), 11);
        end
        rst = 1'b0;
        @(negedge clk);
        check("R9", "first phase after reset", int'(mc_phase), 0);
        check("R9", "first ale after reset", int'(ale), 1);
    endtask

    task automatic test_normal();      run_cycle("R2", 0, 0, 0, 0, 0); endtask
    task automatic test_ext_fetch();   run_cycle("R4", 0, 0, 0, 1, 0); endtask
    task automatic test_xdata_int();   run_cycle("R3", 1, 0, 0, 0, 0); endtask
    task automatic test_xdata_ext();   run_cycle("R5", 1, 0, 0, 1, 0); endtask
    task automatic test_table_ext();   run_cycle("R4", 0, 1, 0, 1, 0); endtask
    task automatic test_quiet_idle();  run_cycle("R6", 0, 0, 1, 0, 0); endtask
    task automatic test_quiet_table(); run_cycle("R7", 0, 1, 1, 0, 0); endtask
    task automatic test_quiet_xdata(); run_cycle("R7", 1, 0, 1, 0, 0); endtask
    task automatic test_quiet_ext();   run_cycle("R8", 0, 0, 1, 1, 0); endtask
    task automatic test_quiet_ext_x(); run_cycle("R8", 1, 0, 1, 1, 0); endtask
    task automatic test_mid_change();
        run_cycle("R10", 0, 0, 0, 1, 1);
        run_cycle("R10", 1, 1, 1, 0, 1);
    endtask
    task automatic test_wrap();
        for (int c = 0; c < 3; c++) run_cycle("R1", 0, 0, 0, 0, 0);
    endtask

    initial begin
        test_reset();
        test_normal();
        test_ext_fetch();
        test_xdata_int();
        test_xdata_ext();
        test_table_ext();
        test_quiet_idle();
        test_quiet_table();
        test_quiet_xdata();
        test_quiet_ext();
        test_quiet_ext_x();
        test_mid_change();
        test_wrap();
        test_reset();
        test_normal();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule